// File: doc/BRIEF.md
# Inbound Address Window Translator

This block sits behind an inbound bus target and decides, one address at a time, whether the address lies in a programmable window. A window is set by a base value and a mask value. An address belongs to the window when the address, masked, equals the base. When a memory command hits the window, the block produces a 32-bit internal address. The bits that the mask clears come from the inbound address, and a translate value is ORed on top of them.

The bottom 4 KB of every window is kept for a messaging function. An access there is still claimed, but it is flagged for the messaging path and is not translated. Configuration commands never use this path. Any burst order other than linear incrementing tells the protocol engine to disconnect after the first data phase.

Software programs the window through a small register write port, which holds the base, the mask, the translate value and an enable bit. The result is registered and appears one clock after the address strobe.

Top module: `iwt_window_xlate`

## Requirements
- R1: After synchronous reset, the base, mask and translate registers hold zero and the enable bit is clear. Every result output (`res_valid`, `claim`, `msg_hit`, `fwd`, `disconnect`, `xlat_addr`) is zero.
- R2: A strobed address is claimed only when all of these hold: the enable bit is set, the command is a memory read or memory write, and (address AND mask) equals the base.
- R3: For a claimed access outside the messaging region, `fwd` is 1 and `xlat_addr` equals (address AND NOT mask) OR translate value.
- R4: A claimed address whose bits [31:12] equal base bits [31:12] sets `msg_hit`. For such an address `fwd` is 0 and `xlat_addr` is zero. When there is no claim, `msg_hit` is 0.
- R5: Command encoding is 0 = memory read, 1 = memory write, 2 = configuration read, 3 = configuration write. Codes 2 and 3 are never claimed, whatever the address.
- R6: The results appear in the cycle after a cycle with `addr_valid` high, with `res_valid` high. After a cycle with `addr_valid` low, all result outputs are zero.
- R7: Burst encoding 0 is linear incrementing, and 1, 2 and 3 are other orders. A claimed access with a burst code other than 0 raises `disconnect`. Linear bursts and unclaimed accesses never do.
- R8: With the enable bit clear, no address is claimed. This holds even with a zero mask and a zero base, which would otherwise match every address.
- R9: Register writes use `cfg_sel` 0 = base, 1 = mask, 2 = translate value, 3 = control (bit 0 = enable). A write in the same cycle as an address strobe does not affect that address. It applies from the next strobe onward.
- R10: A translate value with bits that overlap the mask's zero bits is accepted unchanged and ORed in as written. Aliasing is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Inbound address strobe |
| addr | input | 32 | Inbound bus address |
| cmd | input | 2 | Command code |
| burst | input | 2 | Burst order code |
| res_valid | output | 1 | Result valid, one cycle after strobe |
| claim | output | 1 | Address claimed by the window |
| msg_hit | output | 1 | Claimed access lies in the messaging region |
| fwd | output | 1 | Claimed access is forwarded with translation |
| disconnect | output | 1 | Disconnect after the first data phase |
| xlat_addr | output | 32 | Translated internal address |

## Verification
The assertions assume that `cmd` and `burst` are valid codes whenever `addr_valid` is high. They also assume that `addr_valid` stays low while reset is active, so the first result cycle after reset is a true idle. The stimulus changes inputs only on the falling clock edge, keeps the strobe low through reset, and draws every command and burst value from the defined two-bit codes. Register writes are made in idle cycles, except in the one test that places a write on the same edge as a strobe on purpose.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    localparam int ADDR_W        = 32;
    localparam int MSG_SPAN_BITS = 12;
    localparam int REG_SEL_W     = 2;
    localparam int CODE_W        = 2;
    localparam int PAGE_W        = ADDR_W - MSG_SPAN_BITS;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [CODE_W-1:0] {
        CMD_MEM_RD = 2'd0,
        CMD_MEM_WR = 2'd1,
        CMD_CFG_RD = 2'd2,
        CMD_CFG_WR = 2'd3
    } cmd_e;

    typedef enum logic [CODE_W-1:0] {
        BURST_LINEAR = 2'd0,
        BURST_TOGGLE = 2'd1,
        BURST_WRAP   = 2'd2,
        BURST_RSVD   = 2'd3
    } burst_e;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_BASE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_XLATE = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        addr_t base;
        addr_t mask;
        addr_t xlate;
        logic  enable;
    } window_cfg_t;

    typedef struct packed {
        logic  valid;
        logic  claim;
        logic  msg_hit;
        logic  fwd;
        logic  disconnect;
        addr_t xlat_addr;
    } result_t;

    localparam result_t RESULT_IDLE = '0;

    // Window membership: masked address equals the programmed base.
    function automatic logic window_match(input addr_t a, input addr_t m, input addr_t b);
        return (a & m) == b;
    endfunction

    // Translation: keep the bits the mask leaves free, overlay translate value.
    function automatic addr_t remap(input addr_t a, input addr_t m, input addr_t x);
        return (a & ~m) | x;
    endfunction

    // Messaging region: same 4 KB page as the window base.
    function automatic logic same_page(input addr_t a, input addr_t b);
        return a[ADDR_W-1:MSG_SPAN_BITS] == b[ADDR_W-1:MSG_SPAN_BITS];
    endfunction

endpackage

// File: rtl/iwt_cfg_regs.sv
module iwt_cfg_regs
    import iwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_SEL_W-1:0] sel,
    input  addr_t                wdata,
    output window_cfg_t          cfg
);

    window_cfg_t cfg_q;
    window_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (reg_sel_e'(sel))
                SEL_BASE:  cfg_d.base   = wdata;
                SEL_MASK:  cfg_d.mask   = wdata;
                SEL_XLATE: cfg_d.xlate  = wdata;
                SEL_CTRL:  cfg_d.enable = wdata[0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/iwt_cmd_classify.sv
module iwt_cmd_classify
    import iwt_pkg::*;
(
    input  logic [CODE_W-1:0] cmd,
    input  logic [CODE_W-1:0] burst,
    output logic              is_mem,
    output logic              nonlinear
);

    cmd_e   cmd_c;
    burst_e burst_c;

    always_comb begin
        cmd_c   = cmd_e'(cmd);
        burst_c = burst_e'(burst);
        unique case (cmd_c)
            CMD_MEM_RD, CMD_MEM_WR: is_mem = 1'b1;
            CMD_CFG_RD, CMD_CFG_WR: is_mem = 1'b0;
            default:                is_mem = 1'b0;
        endcase
        nonlinear = (burst_c != BURST_LINEAR);
    end

endmodule

// File: rtl/iwt_window_match.sv
module iwt_window_match
    import iwt_pkg::*;
(
    input  addr_t       addr,
    input  window_cfg_t cfg,
    output logic        hit,
    output logic        in_msg,
    output addr_t       remapped
);

    logic [PAGE_W-1:0] addr_page;
    logic [PAGE_W-1:0] base_page;

    assign addr_page = addr[ADDR_W-1:MSG_SPAN_BITS];
    assign base_page = cfg.base[ADDR_W-1:MSG_SPAN_BITS];

    always_comb begin
        hit      = cfg.enable && window_match(addr, cfg.mask, cfg.base);
        in_msg   = (addr_page == base_page) && same_page(addr, cfg.base);
        remapped = remap(addr, cfg.mask, cfg.xlate);
    end

endmodule

// File: rtl/iwt_window_xlate.sv
module iwt_window_xlate
    import iwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_SEL_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 addr_valid,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CODE_W-1:0]    cmd,
    input  logic [CODE_W-1:0]    burst,
    output logic                 res_valid,
    output logic                 claim,
    output logic                 msg_hit,
    output logic                 fwd,
    output logic                 disconnect,
    output logic [ADDR_W-1:0]    xlat_addr
);

    window_cfg_t cfg_q;
    logic        win_hit;
    logic        win_msg;
    addr_t       win_addr;
    logic        cmd_mem;
    logic        cmd_nonlin;
    result_t     res_d;
    result_t     res_q;

    iwt_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    iwt_cmd_classify u_cls (
        .cmd       (cmd),
        .burst     (burst),
        .is_mem    (cmd_mem),
        .nonlinear (cmd_nonlin)
    );

    iwt_window_match u_match (
        .addr     (addr),
        .cfg      (cfg_q),
        .hit      (win_hit),
        .in_msg   (win_msg),
        .remapped (win_addr)
    );

    always_comb begin
        res_d = RESULT_IDLE;
        if (addr_valid) begin
            res_d.valid      = 1'b1;
            res_d.claim      = win_hit && cmd_mem;
            res_d.msg_hit    = res_d.claim && win_msg;
            res_d.fwd        = res_d.claim && !win_msg;
            res_d.disconnect = res_d.claim && cmd_nonlin;
            res_d.xlat_addr  = res_d.fwd ? win_addr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RESULT_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign claim      = res_q.claim;
    assign msg_hit    = res_q.msg_hit;
    assign fwd        = res_q.fwd;
    assign disconnect = res_q.disconnect;
    assign xlat_addr  = res_q.xlat_addr;

endmodule

// File: rtl/iwt_window_xlate_chk.sv
module iwt_window_xlate_chk
    import iwt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              addr_valid,
    input logic [CODE_W-1:0] cmd,
    input logic [CODE_W-1:0] burst,
    input logic              win_en,
    input logic              res_valid,
    input logic              claim,
    input logic              msg_hit,
    input logic              fwd,
    input logic              disconnect,
    input logic [ADDR_W-1:0] xlat_addr
);

    AST_RESULT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> res_valid); // R6

    AST_IDLE_AFTER_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> (!res_valid && !claim && !disconnect && xlat_addr == '0)); // R6

    AST_CFG_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && cmd[1]) |=> !claim); // R5

    AST_DISABLED_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !win_en) |=> !claim); // R8

    AST_MSG_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        msg_hit |-> (claim && !fwd && xlat_addr == '0)); // R4

    AST_FWD_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        fwd |-> claim); // R3

    AST_CLAIM_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        claim |-> $onehot({msg_hit, fwd})); // R2

    AST_LINEAR_NO_DISC: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && burst == 2'd0) |=> !disconnect); // R7

    AST_DISC_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        disconnect |-> claim); // R7

endmodule

bind iwt_window_xlate iwt_window_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .cmd        (cmd),
    .burst      (burst),
    .win_en     (cfg_q.enable),
    .res_valid  (res_valid),
    .claim      (claim),
    .msg_hit    (msg_hit),
    .fwd        (fwd),
    .disconnect (disconnect),
    .xlat_addr  (xlat_addr)
);

// File: tb/sim_iwt_window_xlate.sv
module sim_iwt_window_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 12;
    localparam int NRAND      = 300;

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  c;
        logic [1:0]  b;
        logic        e_claim;
        logic        e_msg;
        logic        e_disc;
        logic [31:0] e_xlat;
    } vec_t;

    // Window: base 4000_0000, mask F000_0000, translate A000_0000
    localparam vec_t TBL [NVEC] = '{
        '{32'h4000_1000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'hA000_1000},
        '{32'h4000_0FFC, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0000},
        '{32'h4000_0000, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0000},
        '{32'h4FFF_FFFC, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 32'hAFFF_FFFC},
        '{32'h5000_0000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h3FFF_FFFC, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h4012_3450, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h4012_3450, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h4000_2000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 32'hA000_2000},
        '{32'h4000_0800, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 32'h0000_0000},
        '{32'h4ABC_DEF0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'hAABC_DEF0},
        '{32'hC000_1000, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  cmd = '0;
    logic [1:0]  burst = '0;
    logic        res_valid, claim, msg_hit, fwd, disconnect;
    logic [31:0] xlat_addr;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    // bench copy of the programmed window
    logic [31:0] m_base = '0, m_mask = '0, m_xl = '0;
    logic        m_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iwt_window_xlate u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .addr_valid(addr_valid), .addr(addr), .cmd(cmd), .burst(burst),
        .res_valid(res_valid), .claim(claim), .msg_hit(msg_hit), .fwd(fwd),
        .disconnect(disconnect), .xlat_addr(xlat_addr)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (s)
            2'd0: m_base = d;
            2'd1: m_mask = d;
            2'd2: m_xl = d;
            default: m_en = d[0];
        endcase
    endtask

    // drive one strobe at a falling edge; results are registered at the next rising edge
    task automatic strobe(input logic [31:0] a, input logic [1:0] c, input logic [1:0] b);
        addr_valid = 1'b1; addr = a; cmd = c; burst = b;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic ec, input logic em, input logic ed, input logic [31:0] ex);
        check(req, "res_valid", {31'd0, res_valid}, 32'd1);
        check(req, "claim", {31'd0, claim}, {31'd0, ec});
        check(req, "msg_hit", {31'd0, msg_hit}, {31'd0, em});
        check(req, "fwd", {31'd0, fwd}, {31'd0, ec & ~em});
        check(req, "disconnect", {31'd0, disconnect}, {31'd0, ed});
        check(req, "xlat_addr", xlat_addr, ex);
    endtask

    task automatic model_check(input string req, input logic [31:0] a, input logic [1:0] c, input logic [1:0] b);
        logic ec, em, ed;
        logic [31:0] ex;
        ec = m_en && !c[1] && ((a & m_mask) == m_base);
        em = ec && (a[31:12] == m_base[31:12]);
        ed = ec && (b != 2'd0);
        ex = (ec && !em) ? ((a & ~m_mask) | m_xl) : 32'h0;
        strobe(a, c, b);
        expect_res(req, ec, em, ed, ex);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at ports
        check("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        check("R1", "claim", {31'd0, claim}, 32'd0);
        check("R1", "xlat_addr", xlat_addr, 32'd0);
        // R1/R8: zero regs, enable clear -> nothing claimed
        model_check("R1", 32'h0000_0000, 2'd0, 2'd0);
        check("R1", "claim after reset", {31'd0, claim}, 32'd0);

        // R8: zero mask + zero base, enable off, then on
        model_check("R8", 32'h1234_5678, 2'd0, 2'd0);
        wr_reg(2'd3, 32'h1);
        model_check("R8", 32'h1234_5678, 2'd0, 2'd0);
        check("R8", "claim enabled zero window", {31'd0, claim}, 32'd1);
        model_check("R4", 32'h0000_0ABC, 2'd1, 2'd0);
        check("R4", "msg at zero page", {31'd0, msg_hit}, 32'd1);

        // R2 R3 R4 R5 R7: vector table
        wr_reg(2'd0, 32'h4000_0000);
        wr_reg(2'd1, 32'hF000_0000);
        wr_reg(2'd2, 32'hA000_0000);
        for (int i = 0; i < NVEC; i++) begin
            strobe(TBL[i].a, TBL[i].c, TBL[i].b);
            expect_res("R2_R3_R4_R5_R7", TBL[i].e_claim, TBL[i].e_msg, TBL[i].e_disc, TBL[i].e_xlat);
        end

        // R6: idle cycle gives zero outputs
        @(negedge clk);
        check("R6", "idle res_valid", {31'd0, res_valid}, 32'd0);
        check("R6", "idle claim", {31'd0, claim}, 32'd0);

        // R7: every burst code on a claimed forward address
        for (int b = 0; b < 4; b++) begin
            model_check("R7", 32'h4000_5000, 2'd0, b[1:0]);
            check("R7", "disconnect per code", {31'd0, disconnect}, {31'd0, (b != 0)});
        end

        // R9: write on same edge as strobe uses old base
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h6000_0000;
        addr_valid = 1'b1; addr = 32'h4000_3000; cmd = 2'd0; burst = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; addr_valid = 1'b0;
        expect_res("R9", 1'b1, 1'b0, 1'b0, 32'hA000_3000);
        m_base = 32'h6000_0000;
        model_check("R9", 32'h4000_3000, 2'd0, 2'd0);
        check("R9", "old window dropped", {31'd0, claim}, 32'd0);
        model_check("R9", 32'h6000_3000, 2'd0, 2'd0);
        check("R9", "new window claims", {31'd0, claim}, 32'd1);

        // R10: unaligned translate value ORed as written
        wr_reg(2'd2, 32'hA800_0001);
        strobe(32'h6400_2010, 2'd1, 2'd0);
        expect_res("R10", 1'b1, 1'b0, 1'b0, 32'hAC00_2011);

        // R8: disable again
        wr_reg(2'd3, 32'h0);
        model_check("R8", 32'h6000_3000, 2'd0, 2'd0);
        check("R8", "disabled again", {31'd0, claim}, 32'd0);

        // random sweep, half targeted into the window
        wr_reg(2'd3, 32'h1);
        wr_reg(2'd1, 32'hFFF0_0000);
        wr_reg(2'd0, 32'h6000_0000);
        wr_reg(2'd2, 32'h1230_0000);
        for (int n = 0; n < NRAND; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 2 == 0) r = {12'h600, r[19:0]};
            if (n % 7 == 0) r[19:12] = 8'h00;
            model_check("R2_R3_R4", r, 2'($urandom % 4), 2'($urandom % 4));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule